// File: doc/BRIEF.md
# Exception Return Integrity Checker

This block judges whether an exception-return request from a small microcontroller-class core is legal. It works in two phases. In the first phase, before anything is taken off the stack, it reads the special return value and the completion status that the interrupt controller reports for the exception being left. It then either starts unstacking or faults at once on the frame that is already on the stack. In the second phase, once the caller has popped the frame, it compares the exception number in the restored status word with the mode that was requested. A mismatch raises a fault that pushes a fresh frame.

The caller drives one request pulse, waits for a pop strobe, performs the pop, and presents the restored status word and stack pointer with an unstack pulse. Every verdict is reported as a single-cycle done pulse with a two-bit result. The fault outputs tell the surrounding core to set the invalid-PC status bit, pend a usage fault and re-enter the exception through a redirected return value. Memory traffic and the interrupt controller are outside this block.

Top module: `excret_guard`

## Requirements
- R1: The low nibble of `ret_value` selects the target: 4'h1 is Handler mode, 4'h9 is Thread mode on the main stack, 4'hD is Thread mode on the process stack. Any other nibble is a first-phase fault. The cycle after the request, `done`=1 with `result`=2'b01, `invpc_set`=1, `ufault_pend`=1, `pop_go`=0, and `redirect_value` = `ret_value` with bits 31:28 forced to 4'hF.
- R2: A Thread-mode return (4'h9 or 4'hD) with `cmpl_status`=2'b00 (other exceptions still active) faults as in R1 when `nbt_en`=0. It proceeds when `nbt_en`=1.
- R3: `cmpl_status`=2'b10 or 2'b11 (the exception was not active) faults as in R1 for any nibble. `cmpl_status`=2'b01 means the core is back at base level.
- R4: One cycle after every accepted request, `fmask_clr` pulses unless `cur_exc` equals 2 (the NMI number).
- R5: `hibits_warn` pulses one cycle after an accepted request whose bits 27:5 are not all ones. The verdict is unaffected.
- R6: A request that passes the first phase pulses `pop_go` the next cycle with no `done`. `sel_process_sp` then holds 1 for nibble 4'hD and 0 for 4'h1 or 4'h9 until the next passing request.
- R7: After `unstack_valid`, the block faults if Handler was requested and `restored_psr[8:0]` is zero, or if Thread was requested and it is nonzero. The next cycle gives `done`=1, `result`=2'b10, `push_go`=1, `invpc_set`=1, `ufault_pend`=1 and an updated `redirect_value`. Otherwise `result`=2'b00 with no fault outputs.
- R8: On the cycle after `unstack_valid`, `sp_out` = `restored_sp` with bit 2 set when `restored_psr[9]`=1, else `restored_sp` unchanged. It holds until the next unstack.
- R9: A request with `cur_exc`=0, or one that arrives while the block waits for an unstack, is ignored: no output pulses and no change to held outputs. `unstack_valid` outside the waiting phase is also ignored.
- R10: `done` lasts one cycle per verdict and `result` is never 2'b11. Back-to-back requests each get their own verdict.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception-return request strobe |
| ret_value | input | 32 | Special return value written to the PC |
| cur_exc | input | 9 | Number of the exception being left |
| nbt_en | input | 1 | Allow Thread return while still nested |
| cmpl_status | input | 2 | 00 nested, 01 at base, 1x not active |
| unstack_valid | input | 1 | Restored frame is presented |
| restored_psr | input | 32 | Popped status word |
| restored_sp | input | 32 | Stack pointer after pop |
| sel_process_sp | output | 1 | Target stack is the process stack |
| pop_go | output | 1 | First phase passed, pop the frame |
| push_go | output | 1 | Second-phase fault, push a new frame |
| invpc_set | output | 1 | Set invalid-PC fault status bit |
| ufault_pend | output | 1 | Pend usage fault |
| fmask_clr | output | 1 | Clear fault mask |
| hibits_warn | output | 1 | Return value high bits not all ones |
| redirect_value | output | 32 | Return value tagged for fault re-entry |
| sp_out | output | 32 | Stack pointer with alignment pad undone |
| done | output | 1 | Verdict strobe |
| result | output | 2 | 00 ok, 01 fault old frame, 10 fault new frame |

## Verification
The hardest case to reach is the second-phase fault. A request has to pass every first-phase check before the mismatching restored status word can be presented. The stimulus therefore sends only passing Handler and Thread requests, then pops frames whose exception field contradicts the requested mode. A related hard case is a request arriving during the wait for an unstack. The bench injects that extra request between the pop strobe and the unstack pulse and confirms that nothing moves.

// File: rtl/excret_pkg.sv
package excret_pkg;

    typedef enum logic [1:0] {
        RES_OK        = 2'b00,
        RES_FAULT_OLD = 2'b01,
        RES_FAULT_NEW = 2'b10
    } result_e;

    typedef enum logic [1:0] {
        RK_HANDLER    = 2'd0,
        RK_THREAD_MSP = 2'd1,
        RK_THREAD_PSP = 2'd2,
        RK_ILLEGAL    = 2'd3
    } ret_kind_e;

    localparam logic [3:0] NIB_HANDLER    = 4'h1;
    localparam logic [3:0] NIB_THREAD_MSP = 4'h9;
    localparam logic [3:0] NIB_THREAD_PSP = 4'hD;

    localparam logic [1:0] CS_NESTED = 2'b00;
    localparam logic [1:0] CS_BASE   = 2'b01;

    localparam logic [3:0] FAULT_TAG = 4'hF;

endpackage

// File: rtl/excret_decode.sv
module excret_decode
    import excret_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int HI_LO = 5,
    parameter int HI_HI = 27
) (
    input  logic [XLEN-1:0] ret_value,
    input  logic [1:0]      cmpl_status,
    input  logic            nbt_en,
    output ret_kind_e       kind,
    output logic            to_handler,
    output logic            to_process,
    output logic            verdict_fault,
    output logic            hibits_bad
);
    localparam int HI_N = HI_HI - HI_LO + 1;

    logic [HI_N-1:0] hi_field;
    logic            not_active;
    logic            nested;
    logic            thread_blocked;

    always_comb begin
        unique case (ret_value[3:0])
            NIB_HANDLER:    kind = RK_HANDLER;
            NIB_THREAD_MSP: kind = RK_THREAD_MSP;
            NIB_THREAD_PSP: kind = RK_THREAD_PSP;
            default:        kind = RK_ILLEGAL;
        endcase
    end

    assign hi_field   = ret_value[HI_HI:HI_LO];
    assign hibits_bad = ~(&hi_field);

    assign not_active     = cmpl_status[1];
    assign nested         = (cmpl_status == CS_NESTED);
    assign to_handler     = (kind == RK_HANDLER);
    assign to_process     = (kind == RK_THREAD_PSP);
    assign thread_blocked = (kind == RK_THREAD_MSP || kind == RK_THREAD_PSP)
                            && nested && !nbt_en;

    assign verdict_fault = not_active || (kind == RK_ILLEGAL) || thread_blocked;

endmodule

// File: rtl/excret_mode_check.sv
module excret_mode_check #(
    parameter int XLEN      = 32,
    parameter int EXC_W     = 9,
    parameter int ALIGN_BIT = 9,
    parameter int PAD_BIT   = 2
) (
    input  logic            want_handler,
    input  logic [XLEN-1:0] restored_psr,
    input  logic [XLEN-1:0] restored_sp,
    output logic            mismatch,
    output logic [XLEN-1:0] sp_fixed
);
    localparam logic [XLEN-1:0] PAD_MASK = XLEN'(1) << PAD_BIT;

    logic exc_is_zero;

    assign exc_is_zero = (restored_psr[EXC_W-1:0] == '0);
    assign mismatch    = (want_handler == exc_is_zero);

    generate
        if (ALIGN_BIT < XLEN) begin : g_pad
            assign sp_fixed = restored_psr[ALIGN_BIT] ? (restored_sp | PAD_MASK)
                                                      : restored_sp;
        end else begin : g_nopad
            assign sp_fixed = restored_sp;
        end
    endgenerate

endmodule

// File: rtl/excret_guard.sv
module excret_guard
    import excret_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int EXC_W     = 9,
    parameter int NMI_NUM   = 2,
    parameter int ALIGN_BIT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [XLEN-1:0]  ret_value,
    input  logic [EXC_W-1:0] cur_exc,
    input  logic             nbt_en,
    input  logic [1:0]       cmpl_status,
    input  logic             unstack_valid,
    input  logic [XLEN-1:0]  restored_psr,
    input  logic [XLEN-1:0]  restored_sp,
    output logic             sel_process_sp,
    output logic             pop_go,
    output logic             push_go,
    output logic             invpc_set,
    output logic             ufault_pend,
    output logic             fmask_clr,
    output logic             hibits_warn,
    output logic [XLEN-1:0]  redirect_value,
    output logic [XLEN-1:0]  sp_out,
    output logic             done,
    output logic [1:0]       result
);
    localparam int TAG_LO = XLEN - 4;

    typedef struct packed {
        logic            busy;
        logic            want_handler;
        logic            proc_sp;
        logic [XLEN-1:0] ret_hold;
        logic            pop;
        logic            push;
        logic            invpc;
        logic            upend;
        logic            fmclr;
        logic            warn;
        logic            done;
        result_e         res;
        logic [XLEN-1:0] redirect;
        logic [XLEN-1:0] sp;
    } state_t;

    state_t s_d, s_q;

    ret_kind_e       dec_kind;
    logic            dec_handler;
    logic            dec_process;
    logic            dec_fault;
    logic            dec_warn;
    logic            mc_mismatch;
    logic [XLEN-1:0] mc_sp;
    logic            accept_req;
    logic            accept_pop;

    excret_decode #(
        .XLEN (XLEN)
    ) u_decode (
        .ret_value     (ret_value),
        .cmpl_status   (cmpl_status),
        .nbt_en        (nbt_en),
        .kind          (dec_kind),
        .to_handler    (dec_handler),
        .to_process    (dec_process),
        .verdict_fault (dec_fault),
        .hibits_bad    (dec_warn)
    );

    excret_mode_check #(
        .XLEN      (XLEN),
        .EXC_W     (EXC_W),
        .ALIGN_BIT (ALIGN_BIT)
    ) u_mode (
        .want_handler (s_q.want_handler),
        .restored_psr (restored_psr),
        .restored_sp  (restored_sp),
        .mismatch     (mc_mismatch),
        .sp_fixed     (mc_sp)
    );

    assign accept_req = req_valid && !s_q.busy && (cur_exc != '0);
    assign accept_pop = unstack_valid && s_q.busy;

    always_comb begin
        s_d       = s_q;
        s_d.pop   = 1'b0;
        s_d.push  = 1'b0;
        s_d.invpc = 1'b0;
        s_d.upend = 1'b0;
        s_d.fmclr = 1'b0;
        s_d.warn  = 1'b0;
        s_d.done  = 1'b0;
        s_d.res   = RES_OK;

        if (accept_req) begin
            s_d.fmclr = (cur_exc != EXC_W'(NMI_NUM));
            s_d.warn  = dec_warn;
            if (dec_fault) begin
                s_d.invpc    = 1'b1;
                s_d.upend    = 1'b1;
                s_d.done     = 1'b1;
                s_d.res      = RES_FAULT_OLD;
                s_d.redirect = {FAULT_TAG, ret_value[TAG_LO-1:0]};
            end else begin
                s_d.pop          = 1'b1;
                s_d.busy         = 1'b1;
                s_d.want_handler = dec_handler;
                s_d.proc_sp      = dec_process;
                s_d.ret_hold     = ret_value;
            end
        end else if (accept_pop) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.sp   = mc_sp;
            if (mc_mismatch) begin
                s_d.push     = 1'b1;
                s_d.invpc    = 1'b1;
                s_d.upend    = 1'b1;
                s_d.res      = RES_FAULT_NEW;
                s_d.redirect = {FAULT_TAG, s_q.ret_hold[TAG_LO-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_process_sp = s_q.proc_sp;
    assign pop_go         = s_q.pop;
    assign push_go        = s_q.push;
    assign invpc_set      = s_q.invpc;
    assign ufault_pend    = s_q.upend;
    assign fmask_clr      = s_q.fmclr;
    assign hibits_warn    = s_q.warn;
    assign redirect_value = s_q.redirect;
    assign sp_out         = s_q.sp;
    assign done           = s_q.done;
    assign result         = s_q.res;

    p_pop_no_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_go |-> (!invpc_set && !done && !push_go));

    p_push_new_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_go |-> (done && result == RES_FAULT_NEW && ufault_pend));

    p_thread_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !s_q.busy && cur_exc == '0 && !unstack_valid)
        |=> (!done && !pop_go && !fmask_clr && !hibits_warn));

    p_nmi_keeps_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_req && cur_exc == EXC_W'(NMI_NUM)) |=> !fmask_clr);

    p_result_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'b11));

    p_sp_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_pop && restored_psr[ALIGN_BIT]) |=> sp_out[2]);

    p_fault_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        invpc_set |-> (redirect_value[XLEN-1:TAG_LO] == FAULT_TAG));

endmodule

// File: tb/excret_guard_tb.sv
module excret_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] ret_value = '0;
    logic [8:0]  cur_exc = '0;
    logic        nbt_en = 1'b0;
    logic [1:0]  cmpl_status = 2'b01;
    logic        unstack_valid = 1'b0;
    logic [31:0] restored_psr = '0;
    logic [31:0] restored_sp = '0;
    logic        sel_process_sp, pop_go, push_go, invpc_set, ufault_pend;
    logic        fmask_clr, hibits_warn, done;
    logic [31:0] redirect_value, sp_out;
    logic [1:0]  result;

    int    checks = 0;
    int    failures = 0;
    string tag = "R11";

    excret_guard u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ret_value(ret_value),
        .cur_exc(cur_exc), .nbt_en(nbt_en), .cmpl_status(cmpl_status),
        .unstack_valid(unstack_valid), .restored_psr(restored_psr),
        .restored_sp(restored_sp), .sel_process_sp(sel_process_sp),
        .pop_go(pop_go), .push_go(push_go), .invpc_set(invpc_set),
        .ufault_pend(ufault_pend), .fmask_clr(fmask_clr),
        .hibits_warn(hibits_warn), .redirect_value(redirect_value),
        .sp_out(sp_out), .done(done), .result(result)
    );

    always #5 clk = ~clk;

    // reference model state
    bit          m_busy = 0, m_hand = 0, m_psp = 0;
    bit [31:0]   m_hold = 0;
    bit          e_pop = 0, e_push = 0, e_invpc = 0, e_upend = 0, e_fm = 0, e_warn = 0, e_done = 0;
    bit [1:0]    e_res = 0;
    bit [31:0]   e_redir = 0, e_sp = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_hand = 0; m_psp = 0; m_hold = 0;
            e_pop = 0; e_push = 0; e_invpc = 0; e_upend = 0; e_fm = 0; e_warn = 0;
            e_done = 0; e_res = 0; e_redir = 0; e_sp = 0;
        end else begin
            e_pop = 0; e_push = 0; e_invpc = 0; e_upend = 0; e_fm = 0; e_warn = 0;
            e_done = 0; e_res = 0;
            if (req_valid && !m_busy && cur_exc != 0) begin
                int  nib;
                bit  thr, bad;
                nib = ret_value[3:0];
                thr = (nib == 9) || (nib == 13);
                bad = (cmpl_status >= 2) || !(nib == 1 || thr) ||
                      (thr && cmpl_status == 0 && !nbt_en);
                e_fm   = (cur_exc != 2);
                e_warn = (ret_value[27:5] != 23'h7FFFFF);
                if (bad) begin
                    e_invpc = 1; e_upend = 1; e_done = 1; e_res = 1;
                    e_redir = ret_value | 32'hF000_0000;
                end else begin
                    e_pop = 1; m_busy = 1; m_hand = (nib == 1); m_psp = (nib == 13);
                    m_hold = ret_value;
                end
            end else if (unstack_valid && m_busy) begin
                m_busy = 0; e_done = 1;
                e_sp = restored_psr[9] ? (restored_sp | 32'd4) : restored_sp;
                if (m_hand == (restored_psr[8:0] == 0)) begin
                    e_push = 1; e_invpc = 1; e_upend = 1; e_res = 2;
                    e_redir = m_hold | 32'hF000_0000;
                end
            end
        end
    end

    task automatic cmp(string sig, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", tag, sig, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cmp("done",    32'(done),           32'(e_done));
            cmp("result",  32'(result),         32'(e_res));
            cmp("pop_go",  32'(pop_go),         32'(e_pop));
            cmp("push_go", 32'(push_go),        32'(e_push));
            cmp("invpc",   32'(invpc_set),      32'(e_invpc));
            cmp("upend",   32'(ufault_pend),    32'(e_upend));
            cmp("fmclr",   32'(fmask_clr),      32'(e_fm));
            cmp("warn",    32'(hibits_warn),    32'(e_warn));
            cmp("psp",     32'(sel_process_sp), 32'(m_psp));
            cmp("redir",   redirect_value,      e_redir);
            cmp("sp",      sp_out,              e_sp);
        end
    end

    task automatic req(logic [31:0] rv, logic [8:0] ex, logic nb, logic [1:0] st);
        @(negedge clk);
        req_valid = 1; ret_value = rv; cur_exc = ex; nbt_en = nb; cmpl_status = st;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic pop(logic [31:0] psr, logic [31:0] sp);
        @(negedge clk);
        unstack_valid = 1; restored_psr = psr; restored_sp = sp;
        @(negedge clk);
        unstack_valid = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        tag = "R11"; idle(3);

        tag = "R1";
        for (int n = 0; n < 16; n++) begin
            req(32'hFFFF_FFE0 | 32'(n), 9'd5, 1'b0, 2'b01);
            if (n == 1) pop(32'h0000_0003, 32'h2000_1000);
            else if (n == 9 || n == 13) pop(32'h0100_0000, 32'h2000_2000);
            idle(1);
        end

        tag = "R2";
        req(32'hFFFF_FFE9, 9'd11, 1'b0, 2'b00); idle(1);
        req(32'hFFFF_FFFD, 9'd11, 1'b0, 2'b00); idle(1);
        req(32'hFFFF_FFFD, 9'd11, 1'b1, 2'b00); pop(32'h0, 32'h2000_3000); idle(1);
        req(32'hFFFF_FFE1, 9'd11, 1'b0, 2'b00); pop(32'h0B, 32'h2000_3100); idle(1);

        tag = "R3";
        req(32'hFFFF_FFE1, 9'd6, 1'b1, 2'b10); idle(1);
        req(32'hFFFF_FFF9, 9'd6, 1'b1, 2'b11); idle(1);

        tag = "R4";
        req(32'hFFFF_FFE1, 9'd2, 1'b0, 2'b01); pop(32'h2, 32'h1000_0000); idle(1);
        req(32'hFFFF_FFE7, 9'd2, 1'b0, 2'b01); idle(1);
        req(32'hFFFF_FFE7, 9'd3, 1'b0, 2'b01); idle(1);

        tag = "R5";
        req(32'hFFFF_7FE9, 9'd4, 1'b0, 2'b01); pop(32'h0, 32'h2000_0400); idle(1);
        req(32'h0000_0021, 9'd4, 1'b0, 2'b01); pop(32'h4, 32'h2000_0500); idle(1);

        tag = "R6";
        req(32'hFFFF_FFFD, 9'd7, 1'b0, 2'b01); idle(2); pop(32'h0, 32'h2000_0600); idle(1);
        req(32'hFFFF_FFE9, 9'd7, 1'b0, 2'b01); pop(32'h0, 32'h2000_0700); idle(1);

        tag = "R7";
        req(32'hFFFF_FFE1, 9'd8, 1'b0, 2'b01); pop(32'h0000_0200, 32'h2000_0800); idle(1);
        req(32'hFFFF_FFF9, 9'd8, 1'b0, 2'b01); pop(32'h0000_0007, 32'h2000_0900); idle(1);
        req(32'hFFFF_FFFD, 9'd8, 1'b0, 2'b01); pop(32'h0000_0100, 32'h2000_0A00); idle(1);

        tag = "R8";
        req(32'hFFFF_FFF9, 9'd9, 1'b0, 2'b01); pop(32'h0000_0200, 32'h2000_0FF0); idle(1);
        req(32'hFFFF_FFF9, 9'd9, 1'b0, 2'b01); pop(32'h0000_0000, 32'h2000_0FF8); idle(1);

        tag = "R9";
        req(32'hFFFF_FFE7, 9'd0, 1'b0, 2'b10); idle(1);
        pop(32'h0000_0200, 32'h3000_0000); idle(1);
        req(32'hFFFF_FFFD, 9'd5, 1'b0, 2'b01);
        req(32'hFFFF_FFE3, 9'd5, 1'b0, 2'b10); idle(1);
        pop(32'h0, 32'h2000_0B00); idle(1);

        tag = "R10";
        @(negedge clk);
        req_valid = 1; ret_value = 32'hFFFF_FFE5; cur_exc = 9'd12; cmpl_status = 2'b01;
        @(negedge clk);
        ret_value = 32'hFFFF_FFEF;
        @(negedge clk);
        ret_value = 32'hFFFF_FFE1;
        @(negedge clk);
        req_valid = 0;
        pop(32'h0C, 32'h2000_0C00); idle(2);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule